// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block turns a 32-bit virtual address into a physical address in the same cycle it is presented. Each of its 64 slots stores one page mapping together with the identifier of the process that owns it. A lookup therefore matches only mappings that belong to the current process, or mappings marked as shared by all processes. Because of this, the operating system can change context without clearing the table. Pages are 4 KB, so the low 12 address bits are not translated. A cache can start its index access from those bits while the translation runs in parallel.

The three top address bits select a region. The user region and the upper kernel region go through the table. The two middle kernel regions are direct windows onto the low 512 MB of physical memory: one cacheable, one not. A lookup that finds no mapping raises `miss`. A software handler then loads a slot of its choice through the write port, and it can inspect any slot through the read port. The block keeps a referenced bit and a modified bit for every slot up to date.

Top module: `asid_tlb`

## Requirements
- R1: Physical address bits 11:0 always equal virtual address bits 11:0. Virtual address bits 31:12 form the virtual page number.
- R2: In a translated region, a slot hits when it is valid, its page number equals the address page number, and either its identifier equals `lkAsid` or its shared bit is set. The hit appears combinationally in the same cycle, with `paddr` = {frame, offset} and `segment` 0 (user) or 3 (upper kernel).
- R3: A valid slot whose page number matches but whose identifier differs, and whose shared bit is clear, does not hit.
- R4: A translated-region lookup with no matching slot drives `miss`=1, `hit`=0. At most one of `hit`, `miss`, `addrErr` is ever 1.
- R5: Region decode from address bits 31:29 onto `segment`: 0xx gives 0 (user, translated), 100 gives 1 (kernel direct, cacheable), 101 gives 2 (kernel direct, uncached), 11x gives 3 (kernel, translated).
- R6: A supervisor access to region 1 or 2 ignores the table. It drives `hit`=1 and `paddr` = {000, bits 28:0}. `cacheable` is 1 for region 1 and 0 for region 2.
- R7: When `lkUser`=1 and address bit 31 is 1, the block drives `addrErr`=1, `hit`=0 and `miss`=0 whatever the table holds, and the referenced bit of the matching slot stays clear.
- R8: A store (`lkWrite`=1) that hits a slot without write permission drives `protFault`=1 while `hit` stays 1. That slot's modified bit is not set.
- R9: Any translated hit sets the slot's referenced bit, and a permitted store hit also sets its modified bit. Both are visible on the read port from the cycle after the lookup.
- R10: A write-port load is visible from the next cycle. It sets valid, shared, write permission and no-cache from the port, and clears the referenced and modified bits. A lookup in the same cycle as the load sees the old contents, and the load overrides that lookup's bit updates.
- R11: For a translated hit, `cacheable` is the inverse of the slot's no-cache bit.
- R12: After reset every slot is invalid, with its referenced and modified bits clear.
- R13: With `lkValid`=0, `hit`, `miss`, `addrErr` and `protFault` are all 0 and no slot's bits change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | Lookup request this cycle |
| lkAsid | input | 6 | Current process identifier |
| lkVaddr | input | 32 | Virtual address |
| lkWrite | input | 1 | Access is a store |
| lkUser | input | 1 | Access is from user mode |
| wrEn | input | 1 | Load a slot at the clock edge |
| wrIndex | input | 6 | Slot to load |
| wrVpn | input | 20 | Virtual page number to store |
| wrAsid | input | 6 | Process identifier to store |
| wrPfn | input | 20 | Physical frame number to store |
| wrValid | input | 1 | Valid bit to store |
| wrGlobal | input | 1 | Shared bit: match any identifier |
| wrWritable | input | 1 | Write permission to store |
| wrNoCache | input | 1 | No-cache bit to store |
| rdIndex | input | 6 | Slot shown on the read port |
| hit | output | 1 | Translation available |
| miss | output | 1 | No slot matches in a translated region |
| paddr | output | 32 | Physical address |
| protFault | output | 1 | Store to a read-only page |
| addrErr | output | 1 | User access to a kernel region |
| segment | output | 2 | Decoded region code |
| cacheable | output | 1 | Access may be cached |
| rdValid | output | 1 | Valid bit of slot `rdIndex` |
| rdRef | output | 1 | Referenced bit of slot `rdIndex` |
| rdDirty | output | 1 | Modified bit of slot `rdIndex` |

## Verification
The bench targets identifier matching in both directions. A slot with the wrong identifier must miss, and a shared slot must hit under a foreign identifier. A design that ignored the tag or the shared bit would return stale frames or miss needlessly. Stores to read-only pages must fault without marking the page modified. A user access into the upper kernel region must be refused even when a slot matches, and must not mark that slot referenced. The bench also loads a slot in the same cycle as a store lookup to it. A design with write forwarding would return the new frame, and one that let the lookup's update win would leave the reloaded slot marked modified.

// File: rtl/tlbPkg.sv
package tlbPkg;
  parameter int ENTRIES = 64;
  parameter int ASID_W  = 6;
  parameter int VA_W    = 32;
  parameter int PAGE_W  = 12;
  parameter int PFN_W   = 20;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int PA_W   = PFN_W + PAGE_W;
  localparam int TOP_W  = 3;

  typedef enum logic [1:0] {
    SEG_USER      = 2'd0,
    SEG_KDIRECT_C = 2'd1,
    SEG_KDIRECT_U = 2'd2,
    SEG_KMAPPED   = 2'd3
  } segKind_e;

  typedef struct packed {
    logic             touch;
    logic             markDirty;
    logic [IDX_W-1:0] idx;
  } updStrobe_t;
endpackage

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [PFN_W-1:0]  wrPfn,
  input  logic              wrValid,
  input  logic              wrGlobal,
  input  logic              wrWritable,
  input  logic              wrNoCache,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  updStrobe_t        strobe,
  input  logic [IDX_W-1:0]  rdIndex,
  output logic              matchAny,
  output logic [IDX_W-1:0]  matchIdx,
  output logic [PFN_W-1:0]  hitPfn,
  output logic              hitWritable,
  output logic              hitNoCache,
  output logic              rdValid,
  output logic              rdRef,
  output logic              rdDirty,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] refVec,
  output logic [ENTRIES-1:0] dirtyVec
);
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] writeVec;
  logic [ENTRIES-1:0] noCacheVec;
  logic [PFN_W-1:0]   pfnArr [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    logic              vQ, rQ, dQ, gQ, wQ, ncQ;
    logic [VPN_W-1:0]  vpnQ;
    logic [ASID_W-1:0] asidQ;
    logic [PFN_W-1:0]  pfnQ;
    logic              thisWr, thisUpd;

    assign thisWr  = wrEn && (wrIndex == IDX_W'(i));
    assign thisUpd = strobe.touch && (strobe.idx == IDX_W'(i));

    // status bits: a load wins over a lookup update in the same cycle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ <= 1'b0;
        rQ <= 1'b0;
        dQ <= 1'b0;
      end else if (thisWr) begin
        vQ <= wrValid;
        rQ <= 1'b0;
        dQ <= 1'b0;
      end else if (thisUpd) begin
        rQ <= 1'b1;
        if (strobe.markDirty) dQ <= 1'b1;
      end
    end

    // tag and payload fields carry no reset: valid gates their use
    always_ff @(posedge clk) begin
      if (thisWr) begin
        vpnQ  <= wrVpn;
        asidQ <= wrAsid;
        pfnQ  <= wrPfn;
        gQ    <= wrGlobal;
        wQ    <= wrWritable;
        ncQ   <= wrNoCache;
      end
    end

    assign matchVec[i]   = vQ && (vpnQ == lkVpn) && (gQ || (asidQ == lkAsid));
    assign validVec[i]   = vQ;
    assign refVec[i]     = rQ;
    assign dirtyVec[i]   = dQ;
    assign writeVec[i]   = wQ;
    assign noCacheVec[i] = ncQ;
    assign pfnArr[i]     = pfnQ;
  end

  // lowest-numbered matching slot wins if software left duplicates
  always_comb begin
    matchIdx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (matchVec[k]) matchIdx = IDX_W'(k);
    end
  end

  assign matchAny    = |matchVec;
  assign hitPfn      = pfnArr[matchIdx];
  assign hitWritable = writeVec[matchIdx];
  assign hitNoCache  = noCacheVec[matchIdx];
  assign rdValid     = validVec[rdIndex];
  assign rdRef       = refVec[rdIndex];
  assign rdDirty     = dirtyVec[rdIndex];
endmodule

// File: rtl/tlbControl.sv
module tlbControl
  import tlbPkg::*;
(
  input  logic             lkValid,
  input  logic             lkWrite,
  input  logic             lkUser,
  input  logic [VA_W-1:0]  lkVaddr,
  input  logic             matchAny,
  input  logic [IDX_W-1:0] matchIdx,
  input  logic [PFN_W-1:0] hitPfn,
  input  logic             hitWritable,
  input  logic             hitNoCache,
  output logic             hit,
  output logic             miss,
  output logic             protFault,
  output logic             addrErr,
  output logic             cacheable,
  output segKind_e         segKind,
  output logic [PA_W-1:0]  paddr,
  output updStrobe_t       strobe
);
  logic [TOP_W-1:0] topBits;
  logic             mapped;
  logic             tlbHit;
  logic             directHit;

  assign topBits = lkVaddr[VA_W-1 -: TOP_W];

  always_comb begin
    if (!topBits[2])     segKind = SEG_USER;
    else if (topBits[1]) segKind = SEG_KMAPPED;
    else if (topBits[0]) segKind = SEG_KDIRECT_U;
    else                 segKind = SEG_KDIRECT_C;
  end

  assign mapped    = (segKind == SEG_USER) || (segKind == SEG_KMAPPED);
  assign addrErr   = lkValid && lkUser && topBits[2];
  assign tlbHit    = lkValid && !addrErr && mapped && matchAny;
  assign directHit = lkValid && !addrErr && !mapped;
  assign hit       = tlbHit || directHit;
  assign miss      = lkValid && !addrErr && mapped && !matchAny;
  assign protFault = tlbHit && lkWrite && !hitWritable;

  always_comb begin
    if (tlbHit)         cacheable = !hitNoCache;
    else if (directHit) cacheable = (segKind == SEG_KDIRECT_C);
    else                cacheable = 1'b0;
  end

  always_comb begin
    if (tlbHit)         paddr = {hitPfn, lkVaddr[PAGE_W-1:0]};
    else if (directHit) paddr = PA_W'({{TOP_W{1'b0}}, lkVaddr[VA_W-TOP_W-1:0]});
    else                paddr = {{PFN_W{1'b0}}, lkVaddr[PAGE_W-1:0]};
  end

  assign strobe.touch     = tlbHit;
  assign strobe.markDirty = tlbHit && lkWrite && hitWritable;
  assign strobe.idx       = matchIdx;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic              lkWrite,
  input  logic              lkUser,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [PFN_W-1:0]  wrPfn,
  input  logic              wrValid,
  input  logic              wrGlobal,
  input  logic              wrWritable,
  input  logic              wrNoCache,
  input  logic [IDX_W-1:0]  rdIndex,
  output logic              hit,
  output logic              miss,
  output logic [PA_W-1:0]   paddr,
  output logic              protFault,
  output logic              addrErr,
  output logic [1:0]        segment,
  output logic              cacheable,
  output logic              rdValid,
  output logic              rdRef,
  output logic              rdDirty
);
  updStrobe_t         strobe;
  segKind_e           segKind;
  logic               matchAny;
  logic [IDX_W-1:0]   matchIdx;
  logic [PFN_W-1:0]   hitPfn;
  logic               hitWritable;
  logic               hitNoCache;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] refVec;
  logic [ENTRIES-1:0] dirtyVec;

  tlbDatapath u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIndex(wrIndex), .wrVpn(wrVpn), .wrAsid(wrAsid), .wrPfn(wrPfn),
    .wrValid(wrValid), .wrGlobal(wrGlobal), .wrWritable(wrWritable), .wrNoCache(wrNoCache),
    .lkAsid(lkAsid), .lkVpn(lkVaddr[VA_W-1:PAGE_W]),
    .strobe(strobe), .rdIndex(rdIndex),
    .matchAny(matchAny), .matchIdx(matchIdx), .hitPfn(hitPfn),
    .hitWritable(hitWritable), .hitNoCache(hitNoCache),
    .rdValid(rdValid), .rdRef(rdRef), .rdDirty(rdDirty),
    .validVec(validVec), .refVec(refVec), .dirtyVec(dirtyVec)
  );

  tlbControl u_ctl (
    .lkValid(lkValid), .lkWrite(lkWrite), .lkUser(lkUser), .lkVaddr(lkVaddr),
    .matchAny(matchAny), .matchIdx(matchIdx), .hitPfn(hitPfn),
    .hitWritable(hitWritable), .hitNoCache(hitNoCache),
    .hit(hit), .miss(miss), .protFault(protFault), .addrErr(addrErr),
    .cacheable(cacheable), .segKind(segKind), .paddr(paddr), .strobe(strobe)
  );

  assign segment = segKind;
endmodule

// File: rtl/tlbChecker.sv
module tlbChecker
  import tlbPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               lkValid,
  input logic               lkUser,
  input logic [VA_W-1:0]    lkVaddr,
  input logic               hit,
  input logic               miss,
  input logic               protFault,
  input logic               addrErr,
  input logic               cacheable,
  input logic [PA_W-1:0]    paddr,
  input logic               wrEn,
  input logic [IDX_W-1:0]   wrIndex,
  input logic               wrValid,
  input updStrobe_t         strobe,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] dirtyVec,
  input logic [ENTRIES-1:0] refVec
);
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> paddr[PAGE_W-1:0] == lkVaddr[PAGE_W-1:0]);

  assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hit, miss, addrErr}));

  assert_direct_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkUser && lkVaddr[VA_W-1 -: 2] == 2'b10) |->
      (hit && !miss && cacheable == !lkVaddr[VA_W-3] && paddr[PA_W-1 -: TOP_W] == '0));

  assert_user_kernel_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkUser && lkVaddr[VA_W-1]) |-> (addrErr && !hit && !miss && !strobe.touch));

  assert_fault_clean_R8: assert property (@(posedge clk) disable iff (!rstN)
    (protFault && !dirtyVec[strobe.idx] && !(wrEn && wrIndex == strobe.idx)) |=>
      !dirtyVec[$past(strobe.idx)]);

  assert_mark_dirty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.markDirty && !(wrEn && wrIndex == strobe.idx)) |=>
      (dirtyVec[$past(strobe.idx)] && refVec[$past(strobe.idx)]));

  assert_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (validVec[$past(wrIndex)] == $past(wrValid) &&
              !dirtyVec[$past(wrIndex)] && !refVec[$past(wrIndex)]));

  assert_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> (!hit && !miss && !addrErr && !protFault && !strobe.touch));
endmodule

bind asid_tlb tlbChecker u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkUser(lkUser), .lkVaddr(lkVaddr),
  .hit(hit), .miss(miss), .protFault(protFault), .addrErr(addrErr),
  .cacheable(cacheable), .paddr(paddr), .wrEn(wrEn), .wrIndex(wrIndex),
  .wrValid(wrValid), .strobe(strobe), .validVec(validVec), .dirtyVec(dirtyVec),
  .refVec(refVec)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic [5:0]  lkAsid = '0;
  logic [31:0] lkVaddr = '0;
  logic        lkWrite = 1'b0;
  logic        lkUser = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIndex = '0;
  logic [19:0] wrVpn = '0;
  logic [5:0]  wrAsid = '0;
  logic [19:0] wrPfn = '0;
  logic        wrValid = 1'b0, wrGlobal = 1'b0, wrWritable = 1'b0, wrNoCache = 1'b0;
  logic [5:0]  rdIndex = '0;
  logic        hit, miss, protFault, addrErr, cacheable, rdValid, rdRef, rdDirty;
  logic [31:0] paddr;
  logic [1:0]  segment;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAsid(lkAsid), .lkVaddr(lkVaddr),
    .lkWrite(lkWrite), .lkUser(lkUser), .wrEn(wrEn), .wrIndex(wrIndex), .wrVpn(wrVpn),
    .wrAsid(wrAsid), .wrPfn(wrPfn), .wrValid(wrValid), .wrGlobal(wrGlobal),
    .wrWritable(wrWritable), .wrNoCache(wrNoCache), .rdIndex(rdIndex),
    .hit(hit), .miss(miss), .paddr(paddr), .protFault(protFault), .addrErr(addrErr),
    .segment(segment), .cacheable(cacheable), .rdValid(rdValid), .rdRef(rdRef),
    .rdDirty(rdDirty)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic loadSlot(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                          input logic [19:0] pfn, input logic v, input logic g,
                          input logic w, input logic nc);
    @(negedge clk);
    lkValid = 1'b0;
    wrEn = 1'b1; wrIndex = 6'(idx); wrVpn = vpn; wrAsid = asid; wrPfn = pfn;
    wrValid = v; wrGlobal = g; wrWritable = w; wrNoCache = nc;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic present(input logic [5:0] asid, input logic [31:0] va, input logic wr,
                         input logic usr, input logic vld);
    @(negedge clk);
    lkValid = vld; lkAsid = asid; lkVaddr = va; lkWrite = wr; lkUser = usr;
    #5;
  endtask

  task automatic peek(input int idx);
    @(negedge clk);
    lkValid = 1'b0; rdIndex = 6'(idx);
    #5;
  endtask

  task automatic testReset();
    peek(3);
    check("R12 valid after reset", 32'(rdValid), 0);
    check("R12 ref/dirty after reset", {30'd0, rdRef, rdDirty}, 0);
    present(6'd5, 32'h1234_5678, 1'b0, 1'b0, 1'b1);
    check("R12 miss on empty table", {30'd0, hit, miss}, 32'b01);
  endtask

  task automatic testBasicHit();
    loadSlot(3, 20'h12345, 6'd5, 20'hABCDE, 1'b1, 1'b0, 1'b1, 1'b0);
    present(6'd5, 32'h1234_5678, 1'b0, 1'b0, 1'b1);
    check("R2 hit", {30'd0, hit, miss}, 32'b10);
    check("R2 paddr", paddr, 32'hABCD_E678);
    check("R5 user segment", 32'(segment), 0);
    check("R11 cacheable entry", 32'(cacheable), 1);
    peek(3);
    check("R9 ref on read hit", {30'd0, rdRef, rdDirty}, 32'b10);
  endtask

  task automatic testAsid();
    present(6'd6, 32'h1234_5678, 1'b0, 1'b0, 1'b1);
    check("R3 asid mismatch misses", {30'd0, hit, miss}, 32'b01);
    check("R1 offset on miss", 32'(paddr[11:0]), 32'h678);
    loadSlot(10, 20'h00042, 6'd1, 20'h55555, 1'b1, 1'b1, 1'b1, 1'b1);
    present(6'd9, 32'h0004_2ABC, 1'b0, 1'b0, 1'b1);
    check("R2 shared slot hits any asid", {30'd0, hit, miss}, 32'b10);
    check("R2 shared paddr", paddr, 32'h5555_5ABC);
    check("R11 no-cache slot", 32'(cacheable), 0);
  endtask

  task automatic testProtection();
    loadSlot(20, 20'h00100, 6'd5, 20'h0F0F0, 1'b1, 1'b0, 1'b0, 1'b0);
    present(6'd5, 32'h0010_0010, 1'b1, 1'b0, 1'b1);
    check("R8 fault with hit", {30'd0, hit, protFault}, 32'b11);
    peek(20);
    check("R8 ref set, dirty clear", {30'd0, rdRef, rdDirty}, 32'b10);
    present(6'd5, 32'h1234_5000, 1'b1, 1'b0, 1'b1);
    check("R8 no fault on writable", 32'(protFault), 0);
    peek(3);
    check("R9 dirty on permitted store", {30'd0, rdRef, rdDirty}, 32'b11);
  endtask

  task automatic testKernelDirect();
    present(6'd0, 32'h8000_1234, 1'b0, 1'b0, 1'b1);
    check("R6 cached window hit", {30'd0, hit, cacheable}, 32'b11);
    check("R5 segment 1", 32'(segment), 1);
    check("R6 cached window paddr", paddr, 32'h0000_1234);
    present(6'd0, 32'hA000_5678, 1'b0, 1'b0, 1'b1);
    check("R6 uncached window", {30'd0, hit, cacheable}, 32'b10);
    check("R5 segment 2", 32'(segment), 2);
    check("R6 uncached paddr", paddr, 32'h0000_5678);
    present(6'd0, 32'h9FFF_F000, 1'b0, 1'b0, 1'b1);
    check("R6 window top", paddr, 32'h1FFF_F000);
  endtask

  task automatic testUserKernel();
    loadSlot(30, 20'hC0000, 6'd5, 20'h00777, 1'b1, 1'b0, 1'b1, 1'b0);
    present(6'd5, 32'hC000_0004, 1'b0, 1'b1, 1'b1);
    check("R7 user to mapped kernel", {29'd0, addrErr, hit, miss}, 32'b100);
    peek(30);
    check("R7 no ref on address error", 32'(rdRef), 0);
    present(6'd5, 32'hC000_0004, 1'b0, 1'b0, 1'b1);
    check("R2 kernel mapped hit", {30'd0, hit, addrErr}, 32'b10);
    check("R5 segment 3", 32'(segment), 3);
    check("R2 kernel mapped paddr", paddr, 32'h0077_7004);
    present(6'd5, 32'h8000_0000, 1'b0, 1'b1, 1'b1);
    check("R7 user to direct window", {29'd0, addrErr, hit, miss}, 32'b100);
  endtask

  task automatic testIdle();
    loadSlot(40, 20'h00ABC, 6'd2, 20'h12121, 1'b1, 1'b0, 1'b1, 1'b0);
    present(6'd2, 32'h00AB_C000, 1'b1, 1'b0, 1'b0);
    check("R13 idle outputs", {28'd0, hit, miss, addrErr, protFault}, 0);
    peek(40);
    check("R13 idle leaves bits", {30'd0, rdRef, rdDirty}, 0);
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    lkValid = 1'b1; lkAsid = 6'd5; lkVaddr = 32'h1234_5ABC; lkWrite = 1'b1; lkUser = 1'b0;
    wrEn = 1'b1; wrIndex = 6'd3; wrVpn = 20'h12345; wrAsid = 6'd5; wrPfn = 20'h22222;
    wrValid = 1'b1; wrGlobal = 1'b0; wrWritable = 1'b1; wrNoCache = 1'b0;
    #5;
    check("R10 same-cycle lookup sees old", paddr, 32'hABCD_EABC);
    @(posedge clk); #1;
    wrEn = 1'b0;
    peek(3);
    check("R10 load overrides update", {30'd0, rdRef, rdDirty}, 0);
    present(6'd5, 32'h1234_5ABC, 1'b0, 1'b0, 1'b1);
    check("R10 new frame visible", paddr, 32'h2222_2ABC);
    loadSlot(10, 20'h00042, 6'd1, 20'h55555, 1'b0, 1'b1, 1'b1, 1'b1);
    present(6'd1, 32'h0004_2000, 1'b0, 1'b0, 1'b1);
    check("R10 invalidated slot misses", {30'd0, hit, miss}, 32'b01);
    peek(10);
    check("R10 valid cleared", 32'(rdValid), 0);
  endtask

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testBasicHit();
    testAsid();
    testProtection();
    testKernelDirect();
    testUserKernel();
    testIdle();
    testSameCycle();
    @(negedge clk);
    lkValid = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule